// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Software Acknowledge

This block gathers a bank of active-high interrupt request lines and picks, every cycle, the single request with the highest level. Ties within a level are settled by a sub-priority. Each source has a fixed default level and sub-priority. The block presents the winning level and that source's vector number to the processor core. It raises a request to the core only when the winning level beats the core's current mask level. Level 7 cannot be masked.

Two small remap registers let software promote any chosen source into the two highest sub-priority slots of level 6. A remapped source keeps its own vector number. A read-only acknowledge byte lets an interrupt handler ask, just before it returns, whether anything else is waiting. The handler can then jump straight to the next handler without a full exception return. The byte reports the vector of the best pending request even when the core mask hides it, and reads zero when nothing is pending. Reading it disturbs nothing.

Top module: `prio_intc`

## Requirements
- R1: Synchronous active-high reset clears both remap registers to 0 and drives `irq_req`, `irq_level`, `irq_vector` and `bus_rdata` to 0.
- R2: Source n has vector number 64+n. Its default 6-bit key {level[2:0], sub-priority[2:0]} is 63-n for n below 8, so sources 0..7 sit at level 7. For n of 8 and above the key is 61-n, which leaves keys 55 and 54 free.
- R3: Among pending sources, the one with the largest key wins: a higher level first, then a higher sub-priority. One cycle after the inputs are sampled, `irq_level` is the winner's level and `irq_vector` is its vector. Both are 0 when nothing is pending.
- R4: A write to address 0 stores a source index. That source then resolves with key 55 (level 6, sub-priority 7), for example 0x14 for source 20.
- R5: A write to address 1 places the named source at key 54 (level 6, sub-priority 6). If both registers name the same source, key 55 applies.
- R6: A remap value of 0, or of NUM_SRC or above, remaps nothing, and every source keeps its default key.
- R7: `irq_req` is 1 exactly when a request is pending and its level is 7 or greater than the `cpu_mask` value sampled in the same cycle.
- R8: A read of address 2 returns, one cycle later on `bus_rdata`, the vector of the winning pending request whatever the mask, or 0 when nothing is pending.
- R9: A read of address 2 changes no pending state: the following outputs depend only on the request lines.
- R10: Reads of addresses 0 and 1 return the stored 8-bit value, address 3 reads 0, and `bus_rdata` holds its value between reads. Writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_SRC | Active-high request lines, bit n is source n |
| cpu_mask | input | 3 | Current core mask level |
| bus_addr | input | 2 | Register address (0 top remap, 1 second remap, 2 acknowledge, 3 reserved) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| irq_req | output | 1 | Request to the core |
| irq_level | output | 3 | Level of the winning request, 0 if none |
| irq_vector | output | 8 | Vector of the winning request, 0 if none |

## Verification
Several properties are checked on every cycle. An acknowledge read always matches the vector presented to the core in the same sampling cycle. A request to the core always implies a level that is unmasked or equal to 7, and level 7 always raises a request. Level and vector are zero together, and any vector lies in the source range. Which source should win after remap writes, out-of-range remap values and colliding remaps can only be shown by the bench's reference model. The same holds for the absence of side effects from back-to-back acknowledge reads.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int LVL_W    = 3;
    localparam int KEY_W    = 6;
    localparam int VEC_W    = 8;
    localparam int REG_W    = 8;
    localparam int VEC_BASE = 64;

    localparam logic [KEY_W-1:0] KEY_PROMOTE_TOP = 6'd55;
    localparam logic [KEY_W-1:0] KEY_PROMOTE_2ND = 6'd54;

    typedef enum logic [1:0] {
        ADDR_PROMOTE_TOP = 2'd0,
        ADDR_PROMOTE_2ND = 2'd1,
        ADDR_SW_ACK      = 2'd2,
        ADDR_RESERVED    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             valid;
        logic [KEY_W-1:0] key;
        logic [VEC_W-1:0] vec;
    } cand_t;

    // Default key: sources 0..7 fill level 7, the rest start below key 54.
    function automatic logic [KEY_W-1:0] default_key(input int n);
        if (n < 8) return KEY_W'(63 - n);
        return KEY_W'(61 - n);
    endfunction

    function automatic cand_t pick(input cand_t a, input cand_t b);
        if (a.valid && (!b.valid || a.key >= b.key)) return a;
        return b;
    endfunction

endpackage

// File: rtl/intc_remap_regs.sv
module intc_remap_regs
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] top_raw,
    output logic [REG_W-1:0] sec_raw,
    output logic             top_en,
    output logic             sec_en,
    output logic [SRC_W-1:0] top_idx,
    output logic [SRC_W-1:0] sec_idx
);
    logic [REG_W-1:0] slot_q [2];

    for (genvar s = 0; s < 2; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[s] <= '0;
            else if (bus_wr && bus_addr == 2'(s))
                slot_q[s] <= bus_wdata;
        end
    end

    assign top_raw = slot_q[0];
    assign sec_raw = slot_q[1];

    // Zero and out-of-range indices select nothing.
    assign top_en  = (slot_q[0] != '0) && (slot_q[0] < REG_W'(NUM_SRC));
    assign sec_en  = (slot_q[1] != '0) && (slot_q[1] < REG_W'(NUM_SRC));
    assign top_idx = slot_q[0][SRC_W-1:0];
    assign sec_idx = slot_q[1][SRC_W-1:0];
endmodule

// File: rtl/intc_cand_gen.sv
module intc_cand_gen
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               top_en,
    input  logic               sec_en,
    input  logic [SRC_W-1:0]   top_idx,
    input  logic [SRC_W-1:0]   sec_idx,
    output cand_t              cand [NUM_SRC]
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        always_comb begin
            cand[g].valid = irq_src[g];
            cand[g].vec   = VEC_W'(VEC_BASE + g);
            if (top_en && top_idx == SRC_W'(g))
                cand[g].key = KEY_PROMOTE_TOP;
            else if (sec_en && sec_idx == SRC_W'(g))
                cand[g].key = KEY_PROMOTE_2ND;
            else
                cand[g].key = default_key(g);
        end
    end
endmodule

// File: rtl/intc_prio_tree.sv
module intc_prio_tree
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int DEPTH  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0,
    localparam int LEAVES = 1 << DEPTH,
    localparam int NODES  = 2 * LEAVES - 1
) (
    input  cand_t             cand [NUM_SRC],
    output logic              win_valid,
    output logic [LVL_W-1:0]  win_level,
    output logic [VEC_W-1:0]  win_vec
);
    cand_t node [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_SRC) begin : g_real
            assign node[LEAVES-1+i] = cand[i];
        end else begin : g_pad
            assign node[LEAVES-1+i] = '0;
        end
    end

    for (genvar j = 0; j < LEAVES - 1; j++) begin : g_node
        assign node[j] = pick(node[2*j+1], node[2*j+2]);
    end

    assign win_valid = node[0].valid;
    assign win_level = node[0].valid ? node[0].key[KEY_W-1 -: LVL_W] : '0;
    assign win_vec   = node[0].valid ? node[0].vec : '0;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic [2:0]         cpu_mask,
    input  logic [1:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               irq_req,
    output logic [2:0]         irq_level,
    output logic [7:0]         irq_vector
);
    logic [REG_W-1:0] top_raw, sec_raw;
    logic             top_en, sec_en;
    logic [SRC_W-1:0] top_idx, sec_idx;
    cand_t            cand [NUM_SRC];
    logic             win_valid;
    logic [LVL_W-1:0] win_level;
    logic [VEC_W-1:0] win_vec;
    logic             unmasked;
    logic [REG_W-1:0] rd_mux;

    intc_remap_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .top_raw(top_raw), .sec_raw(sec_raw),
        .top_en(top_en), .sec_en(sec_en), .top_idx(top_idx), .sec_idx(sec_idx)
    );

    intc_cand_gen #(.NUM_SRC(NUM_SRC)) u_cand (
        .irq_src(irq_src), .top_en(top_en), .sec_en(sec_en),
        .top_idx(top_idx), .sec_idx(sec_idx), .cand(cand)
    );

    intc_prio_tree #(.NUM_SRC(NUM_SRC)) u_tree (
        .cand(cand), .win_valid(win_valid), .win_level(win_level), .win_vec(win_vec)
    );

    assign unmasked = win_valid && (win_level == 3'd7 || win_level > cpu_mask);

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            ADDR_PROMOTE_TOP: rd_mux = top_raw;
            ADDR_PROMOTE_2ND: rd_mux = sec_raw;
            ADDR_SW_ACK:      rd_mux = win_vec;
            default:          rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req    <= 1'b0;
            irq_level  <= '0;
            irq_vector <= '0;
            bus_rdata  <= '0;
        end else begin
            irq_req    <= unmasked;
            irq_level  <= win_level;
            irq_vector <= win_vec;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] cpu_mask,
    input logic [1:0] bus_addr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       irq_req,
    input logic [2:0] irq_level,
    input logic [7:0] irq_vector
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (irq_level == 3'd0 && irq_vector == 8'd0 && !irq_req && bus_rdata == 8'd0));

    assert_vector_range_R2: assert property (@(posedge clk) disable iff (rst)
        (irq_vector != 8'd0) |-> (int'(irq_vector) >= VEC_BASE && int'(irq_vector) < VEC_BASE + NUM_SRC));

    assert_level_vector_pair_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_level == 3'd0) == (irq_vector == 8'd0));

    assert_req_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_level == 3'd7 || irq_level > $past(cpu_mask)));

    assert_level7_nmi_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_level == 3'd7) |-> irq_req);

    assert_ack_matches_core_R8: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd && bus_addr == ADDR_SW_ACK) |-> (bus_rdata == irq_vector));
endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst(rst), .cpu_mask(cpu_mask), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] irq_src = '0;
    logic [2:0]      cpu_mask = '0;
    logic [1:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic            irq_req;
    logic [2:0]      irq_level;
    logic [7:0]      irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_top = 0, m_sec = 0, m_rdata = 0;
    int e_lvl, e_vec, e_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_intc #(.NUM_SRC(NSRC)) u_prio_intc (
        .clk(clk), .rst(rst), .irq_src(irq_src), .cpu_mask(cpu_mask),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference key of source n per R2, R4, R5, R6.
    function automatic int ref_key(input int n);
        bit top_on = (m_top != 0) && (m_top < NSRC);
        bit sec_on = (m_sec != 0) && (m_sec < NSRC);
        if (top_on && m_top == n) return 55;
        if (sec_on && m_sec == n) return 54;
        return (n < 8) ? 63 - n : 61 - n;
    endfunction

    task automatic step(input logic [NSRC-1:0] src, input int mask, input int addr,
                        input bit wr, input bit rd, input int wdata);
        int best_key = -1;
        int best_src = -1;
        irq_src   = src;
        cpu_mask  = 3'(mask);
        bus_addr  = 2'(addr);
        bus_wr    = wr;
        bus_rd    = rd;
        bus_wdata = 8'(wdata);
        for (int n = 0; n < NSRC; n++) begin
            if (src[n] && ref_key(n) > best_key) begin
                best_key = ref_key(n);
                best_src = n;
            end
        end
        e_vec = (best_src >= 0) ? 64 + best_src : 0;
        e_lvl = (best_src >= 0) ? best_key / 8 : 0;
        e_req = (best_src >= 0) && (e_lvl == 7 || e_lvl > mask);
        if (rd) begin
            case (addr)
                0: m_rdata = m_top;
                1: m_rdata = m_sec;
                2: m_rdata = e_vec;
                default: m_rdata = 0;
            endcase
        end
        if (wr && addr == 0) m_top = wdata & 255;
        if (wr && addr == 1) m_sec = wdata & 255;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(irq_level == 3'(e_lvl), "R3 level", int'(irq_level), e_lvl);
        chk(irq_vector == 8'(e_vec), "R3 vector", int'(irq_vector), e_vec);
        chk(irq_req == e_req[0], "R7 request", int'(irq_req), e_req);
        chk(bus_rdata == 8'(m_rdata), "R10 read data", int'(bus_rdata), m_rdata);
    endtask

    localparam logic [NSRC-1:0] ONE = 1;

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset state
        chk(irq_level == 0 && irq_vector == 0 && !irq_req, "R1 outputs", int'(irq_vector), 0);
        chk(bus_rdata == 0, "R1 rdata", int'(bus_rdata), 0);
        rst = 1'b0;
        step('0, 0, 0, 0, 1, 0);
        chk(bus_rdata == 0, "R1 top remap", int'(bus_rdata), 0);
        step('0, 0, 1, 0, 1, 0);
        chk(bus_rdata == 0, "R1 second remap", int'(bus_rdata), 0);
        // R8: nothing pending reads zero
        step('0, 0, 2, 0, 1, 0);
        chk(bus_rdata == 0, "R8 empty ack", int'(bus_rdata), 0);
        // R2: default placement of source 20 is key 41 -> level 5
        step(ONE << 20, 0, 0, 0, 0, 0);
        chk(irq_level == 5 && irq_vector == 84, "R2 default source 20", int'(irq_level), 5);
        step(ONE << 3, 0, 0, 0, 0, 0);
        chk(irq_level == 7 && irq_vector == 67, "R2 default source 3", int'(irq_vector), 67);
        // R4: promote source 20
        step(ONE << 20, 0, 0, 1, 0, 8'h14);
        step(ONE << 20, 0, 0, 0, 0, 0);
        chk(irq_level == 6 && irq_vector == 84, "R4 promoted level", int'(irq_level), 6);
        // R5: second slot for source 21, below source 20
        step((ONE << 20) | (ONE << 21), 0, 1, 1, 0, 8'h15);
        step((ONE << 20) | (ONE << 21), 0, 0, 0, 0, 0);
        chk(irq_vector == 84, "R5 top slot beats second", int'(irq_vector), 84);
        step((ONE << 21) | (ONE << 8), 0, 0, 0, 0, 0);
        chk(irq_level == 6 && irq_vector == 85, "R5 second slot beats key 53", int'(irq_vector), 85);
        // R5: both registers naming one source use key 55
        step((ONE << 21) | (ONE << 20), 0, 0, 1, 0, 21);
        step((ONE << 21) | (ONE << 20), 0, 0, 0, 0, 0);
        chk(irq_vector == 85 && irq_level == 6, "R5 collision", int'(irq_vector), 85);
        // R6: out-of-range index disables
        step(ONE << 21, 0, 0, 1, 0, 40);
        step(ONE << 21, 0, 0, 0, 1, 0);
        chk(irq_level == 6, "R6 second still active", int'(irq_level), 6);
        step(ONE << 20, 0, 0, 0, 0, 0);
        chk(irq_level == 5, "R6 out of range ignored", int'(irq_level), 5);
        chk(bus_rdata == 40, "R10 raw readback", int'(bus_rdata), 40);
        // R10: writes to the acknowledge address are ignored
        step(ONE << 20, 0, 2, 1, 0, 3);
        step(ONE << 20, 0, 0, 0, 1, 0);
        chk(bus_rdata == 40, "R10 ack write ignored", int'(bus_rdata), 40);
        step(ONE << 20, 0, 3, 0, 1, 0);
        chk(bus_rdata == 0, "R10 reserved reads zero", int'(bus_rdata), 0);
        // R7: level 7 is never masked
        step(ONE << 3, 7, 0, 0, 0, 0);
        chk(irq_req == 1, "R7 level 7 unmaskable", int'(irq_req), 1);
        // R8, R9: masked request visible to acknowledge, reads do not clear it
        step(ONE << 8, 6, 2, 0, 1, 0);
        chk(irq_req == 0, "R7 masked level 6", int'(irq_req), 0);
        chk(bus_rdata == 72, "R8 masked ack", int'(bus_rdata), 72);
        step(ONE << 8, 6, 2, 0, 1, 0);
        chk(bus_rdata == 72 && irq_vector == 72, "R9 ack has no side effect", int'(bus_rdata), 72);
        step(ONE << 8, 5, 0, 0, 0, 0);
        chk(irq_req == 1 && irq_vector == 72, "R9 request still pending", int'(irq_vector), 72);
        // Random traffic compared against the model on every clock
        for (int i = 0; i < 4000; i++) begin
            step($urandom & $urandom & $urandom, $urandom_range(0, 7), $urandom_range(0, 3),
                 ($urandom_range(0, 15) == 0), $urandom_range(0, 1), $urandom_range(0, 40));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule